// File: doc/BRIEF.md
# Preamble and Start-of-Frame Detector

This block watches the recovered bit stream that a demodulator and clock-recovery stage delivers, one bit per cycle in which a valid strobe is high. It decides when a frame begins. It first looks for a training preamble and then, where the link format calls for one, for an 8-bit start-of-frame (SOF) byte. When the frame begins, it emits a single-cycle `frame_start` pulse. The receive path that follows then takes the payload.

Three static configuration inputs select how the detector works. `mod_fm` selects the FM or AM path, `line_manch` selects Manchester or NRZ line coding, and `sof_alt_sel` selects the SOF byte. The table below shows how these combine:

| Path and coding | Preamble | SOF byte |
|---|---|---|
| FM, NRZ | alternating bits | none; frame start is the first bit that breaks the alternation |
| FM, Manchester | a run of identical bits, ones or zeros | 0x55, or 0xAA when `sof_alt_sel` is high |
| AM, NRZ | none (the carrier itself serves as training) | 0x55 |
| AM, Manchester | none (the carrier itself serves as training) | 0x0A |

On the AM path the SOF is searched continuously. On the FM Manchester path the SOF hunt is bounded by a window. If the window expires, the detector raises `sync_lost` for one cycle and starts looking for a preamble again. After a frame start, the detector ignores the stream until the downstream logic signals `frame_done`.

Top module: `frame_sync_detector`

## Requirements
- R1: While and right after a synchronous reset, `frame_start` and `sync_lost` are low and the detector searches for a preamble with an empty bit history.
- R2: FM with NRZ: once the current run of alternating bits reaches the minimum preamble length, the first later bit equal to its predecessor produces `frame_start`, and no SOF byte is checked.
- R3: FM with Manchester: a run of identical bits of either polarity (all ones or all zeros) that reaches the minimum length arms the SOF hunt.
- R4: FM with Manchester: `frame_start` fires on the bit that completes the expected SOF byte. The expected byte is 0x55 when `sof_alt_sel` = 0 and 0xAA when `sof_alt_sel` = 1. The comparison uses the last 8 received bits, with the earliest of them as bit 7.
- R5: AM path: no preamble is checked and the SOF is hunted from the search state without time limit. The byte is 0x55 with NRZ and 0x0A with Manchester, `sof_alt_sel` has no effect, and `sync_lost` never fires.
- R6: FM with Manchester: the SOF hunt covers exactly 32 bits after the qualifying preamble bit. A match on the 32nd bit still starts the frame. Otherwise that bit raises `sync_lost` and the detector returns to preamble search with its history cleared.
- R7: A bit that breaks the preamble pattern before the minimum length restarts the run count at 1, counting that bit.
- R8: After `frame_start`, incoming bits cause no pulse until `frame_done` is high on a clock edge. At that edge the detector clears its history and returns to preamble search.
- R9: Each pulse lasts one cycle and appears in the cycle after the clock edge that sampled the deciding bit. `frame_start` and `sync_lost` are never high together.
- R10: Cycles with `bit_valid` low change no detector state, whatever `bit_in` holds.
- R11: The minimum preamble length comes from `pre_min`, and a value of 0 selects the default of 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | `bit_in` holds a new recovered bit this cycle |
| bit_in | input | 1 | Recovered serial bit |
| mod_fm | input | 1 | 1 = FM path, 0 = AM path |
| line_manch | input | 1 | 1 = Manchester line coding, 0 = NRZ |
| sof_alt_sel | input | 1 | FM Manchester only: 1 selects SOF 0xAA, 0 selects 0x55 |
| pre_min | input | PRE_W (6) | Minimum preamble length in bits; 0 selects the default of 8 |
| frame_done | input | 1 | Downstream finished with the frame; rearms the detector |
| frame_start | output | 1 | One-cycle pulse: a frame begins |
| sync_lost | output | 1 | One-cycle pulse: the SOF hunt window expired |

## Verification
The assertions check, on every cycle, the following properties:
- The two pulses stay exclusive and one cycle wide.
- A frame start always follows a sampled bit.
- `sync_lost` comes only out of an FM Manchester hunt.
- The hunt counter stays inside its window.
- The held state stays quiet.
- The bit history tracks each valid bit.

Other behaviours can only be shown by the bench's scenarios. These are the exact bit on which a frame starts for each path and coding, the SOF byte selection, the restart of a short preamble, the boundary of the 32-bit window, the default length, and the rearm on `frame_done`.

// File: rtl/fsd_pkg.sv
package fsd_pkg;

  localparam int SOF_W = 8;

  localparam logic [SOF_W-1:0] SOF_PLAIN   = 8'h55;
  localparam logic [SOF_W-1:0] SOF_INVERT  = 8'hAA;
  localparam logic [SOF_W-1:0] SOF_AM_MAN  = 8'h0A;

  typedef enum logic [1:0] {
    ST_SEARCH,
    ST_QUAL,
    ST_HUNT,
    ST_HOLD
  } fsd_state_e;

endpackage

// File: rtl/fsd_history.sv
module fsd_history #(
  parameter int PRE_W = 6,
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             bit_valid,
  input  logic             bit_in,
  input  logic             const_run,
  output logic             pat_ok,
  output logic [PRE_W-1:0] run_next,
  output logic [WIN_W-1:0] win_next
);

  localparam logic [PRE_W-1:0] RUN_MAX = '1;

  logic             have_prev;
  logic             prev_bit;
  logic [PRE_W-1:0] run_len;
  logic [WIN_W-1:0] win;

  // The current bit extends the run if it matches the pattern.
  always_comb begin
    if (const_run) pat_ok = have_prev && (bit_in == prev_bit);
    else           pat_ok = have_prev && (bit_in != prev_bit);
  end

  always_comb begin
    if (!pat_ok)               run_next = PRE_W'(1);
    else if (run_len == RUN_MAX) run_next = run_len;
    else                       run_next = run_len + PRE_W'(1);
  end

  assign win_next = {win[WIN_W-2:0], bit_in};

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      have_prev <= 1'b0;
      prev_bit  <= 1'b0;
      run_len   <= '0;
      win       <= '0;
    end else if (bit_valid) begin
      have_prev <= 1'b1;
      prev_bit  <= bit_in;
      run_len   <= run_next;
      win       <= win_next;
    end
  end

  // R10
  prev_track_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && !clear) |=> (prev_bit == $past(bit_in)) && have_prev);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!bit_valid && !clear) |=> $stable(win) && $stable(run_len));

  // R7
  run_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && !clear) |=> (run_len != '0));

endmodule

// File: rtl/fsd_sof_match.sv
module fsd_sof_match
  import fsd_pkg::*;
(
  input  logic             bit_valid,
  input  logic             mod_fm,
  input  logic             line_manch,
  input  logic             sof_alt_sel,
  input  logic [SOF_W-1:0] win_next,
  output logic             sof_hit
);

  logic [SOF_W-1:0] expect_sof;

  always_comb begin
    if (!mod_fm)         expect_sof = line_manch ? SOF_AM_MAN : SOF_PLAIN;
    else if (sof_alt_sel) expect_sof = SOF_INVERT;
    else                 expect_sof = SOF_PLAIN;
  end

  assign sof_hit = bit_valid && (win_next == expect_sof);

endmodule

// File: rtl/fsd_ctrl.sv
module fsd_ctrl
  import fsd_pkg::*;
#(
  parameter int PRE_W       = 6,
  parameter int PRE_MIN_DEF = 8,
  parameter int SOF_WINDOW  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_valid,
  input  logic             mod_fm,
  input  logic             line_manch,
  input  logic [PRE_W-1:0] pre_min,
  input  logic             pat_ok,
  input  logic [PRE_W-1:0] run_next,
  input  logic             sof_hit,
  input  logic             frame_done,
  output logic             hist_clear,
  output logic             frame_start,
  output logic             sync_lost
);

  localparam int               CNT_W    = $clog2(SOF_WINDOW + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SOF_WINDOW - 1);
  localparam logic [PRE_W-1:0] PRE_DEF  = PRE_W'(PRE_MIN_DEF);

  fsd_state_e       state, state_n;
  logic [CNT_W-1:0] hunt_cnt, cnt_n;
  logic             fs_n, sl_n;
  logic [PRE_W-1:0] eff_min;
  logic             pre_ok;

  assign eff_min = (pre_min == '0) ? PRE_DEF : pre_min;
  assign pre_ok  = (run_next >= eff_min);

  always_comb begin
    state_n    = state;
    cnt_n      = hunt_cnt;
    fs_n       = 1'b0;
    sl_n       = 1'b0;
    hist_clear = 1'b0;
    case (state)
      ST_SEARCH: begin
        if (bit_valid) begin
          if (!mod_fm) begin
            if (sof_hit) begin
              fs_n    = 1'b1;
              state_n = ST_HOLD;
            end
          end else if (pre_ok) begin
            cnt_n   = '0;
            state_n = line_manch ? ST_HUNT : ST_QUAL;
          end
        end
      end
      ST_QUAL: begin
        if (bit_valid && !pat_ok) begin
          fs_n    = 1'b1;
          state_n = ST_HOLD;
        end
      end
      ST_HUNT: begin
        if (bit_valid) begin
          if (sof_hit) begin
            fs_n    = 1'b1;
            state_n = ST_HOLD;
          end else if (hunt_cnt == CNT_LAST) begin
            sl_n       = 1'b1;
            hist_clear = 1'b1;
            cnt_n      = '0;
            state_n    = ST_SEARCH;
          end else begin
            cnt_n = hunt_cnt + CNT_W'(1);
          end
        end
      end
      ST_HOLD: begin
        if (frame_done) begin
          hist_clear = 1'b1;
          state_n    = ST_SEARCH;
        end
      end
      default: state_n = ST_SEARCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_SEARCH;
      hunt_cnt    <= '0;
      frame_start <= 1'b0;
      sync_lost   <= 1'b0;
    end else begin
      state       <= state_n;
      hunt_cnt    <= cnt_n;
      frame_start <= fs_n;
      sync_lost   <= sl_n;
    end
  end

  // R9
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(frame_start && sync_lost));

  // R9
  fs_single_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);

  // R9
  sl_single_chk: assert property (@(posedge clk) disable iff (rst)
    sync_lost |=> !sync_lost);

  // R10
  fs_needs_bit_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> $past(bit_valid));

  // R5
  sl_fm_manch_chk: assert property (@(posedge clk) disable iff (rst)
    sync_lost |-> $past(mod_fm && line_manch));

  // R6
  sl_from_hunt_chk: assert property (@(posedge clk) disable iff (rst)
    sync_lost |-> $past(state == ST_HUNT) && (state == ST_SEARCH));

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    hunt_cnt <= CNT_LAST);

  // R8
  hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD && !frame_done) |=> !frame_start && !sync_lost && (state == ST_HOLD));

endmodule

// File: rtl/frame_sync_detector.sv
module frame_sync_detector
  import fsd_pkg::*;
#(
  parameter int PRE_W       = 6,
  parameter int PRE_MIN_DEF = 8,
  parameter int SOF_WINDOW  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_valid,
  input  logic             bit_in,
  input  logic             mod_fm,
  input  logic             line_manch,
  input  logic             sof_alt_sel,
  input  logic [PRE_W-1:0] pre_min,
  input  logic             frame_done,
  output logic             frame_start,
  output logic             sync_lost
);

  logic             hist_clear;
  logic             pat_ok;
  logic [PRE_W-1:0] run_next;
  logic [SOF_W-1:0] win_next;
  logic             sof_hit;

  fsd_history #(
    .PRE_W (PRE_W),
    .WIN_W (SOF_W)
  ) u_history (
    .clk       (clk),
    .rst       (rst),
    .clear     (hist_clear),
    .bit_valid (bit_valid),
    .bit_in    (bit_in),
    .const_run (line_manch),
    .pat_ok    (pat_ok),
    .run_next  (run_next),
    .win_next  (win_next)
  );

  fsd_sof_match u_sof (
    .bit_valid   (bit_valid),
    .mod_fm      (mod_fm),
    .line_manch  (line_manch),
    .sof_alt_sel (sof_alt_sel),
    .win_next    (win_next),
    .sof_hit     (sof_hit)
  );

  fsd_ctrl #(
    .PRE_W       (PRE_W),
    .PRE_MIN_DEF (PRE_MIN_DEF),
    .SOF_WINDOW  (SOF_WINDOW)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .bit_valid   (bit_valid),
    .mod_fm      (mod_fm),
    .line_manch  (line_manch),
    .pre_min     (pre_min),
    .pat_ok      (pat_ok),
    .run_next    (run_next),
    .sof_hit     (sof_hit),
    .frame_done  (frame_done),
    .hist_clear  (hist_clear),
    .frame_start (frame_start),
    .sync_lost   (sync_lost)
  );

endmodule

// File: tb/frame_sync_detector_tb.sv
module frame_sync_detector_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PRE_W = 6;
  localparam int NV = 11;

  // Per vector: path, coding, SOF select, minimum length, bit count,
  // bits sent MSB first, expected frame_start bit, expected sync_lost bit
  // (bit numbers start at 1; 0 = never), requirement number.
  localparam int V_FM  [NV] = '{1, 1, 1, 1, 1, 0, 0, 1, 1, 1, 0};
  localparam int V_MAN [NV] = '{0, 0, 1, 1, 1, 0, 1, 1, 0, 1, 0};
  localparam int V_ALT [NV] = '{0, 0, 0, 1, 0, 1, 0, 0, 0, 1, 0};
  localparam int V_PRE [NV] = '{8, 8, 8, 8, 8, 8, 8, 8, 4, 0, 8};
  localparam int V_N   [NV] = '{9, 15, 16, 16, 16, 12, 10, 48, 5, 40, 40};
  localparam logic [63:0] V_BITS [NV] = '{
    64'h154,              // R2 NRZ alternation then break
    64'h54AB,             // R7 short run restarts
    64'hFF55,             // R3 ones preamble, SOF 0x55
    64'h00AA,             // R4 zeros preamble, SOF 0xAA
    64'h0055,             // R4 zeros preamble, SOF 0x55
    64'h355,              // R5 AM NRZ 0x55, alt select ignored
    64'h30A,              // R5 AM Manchester 0x0A
    64'hFF_0000_0000_55,  // R6 window expiry, then no rearm
    64'h14,               // R11 minimum of 4
    64'hFF_FFFF_FFAA,     // R6 match on 32nd bit, R11 default 8
    64'h0                 // R5 AM zeros, no sync_lost
  };
  localparam int V_FS  [NV] = '{9, 15, 16, 16, 16, 12, 10, 0, 5, 40, 0};
  localparam int V_SL  [NV] = '{0, 0, 0, 0, 0, 0, 0, 40, 0, 0, 0};
  localparam int V_REQ [NV] = '{2, 7, 3, 4, 4, 5, 5, 6, 11, 6, 5};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_valid = 1'b0;
  logic bit_in = 1'b0;
  logic mod_fm = 1'b0;
  logic line_manch = 1'b0;
  logic sof_alt_sel = 1'b0;
  logic [PRE_W-1:0] pre_min = 6'd8;
  logic frame_done = 1'b0;
  logic frame_start, sync_lost;

  int checks = 0;
  int failures = 0;
  int bit_no, fs_cnt, fs_pos, sl_cnt, sl_pos;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_sync_detector #(.PRE_W(PRE_W)) u_dut (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
    .mod_fm(mod_fm), .line_manch(line_manch), .sof_alt_sel(sof_alt_sel),
    .pre_min(pre_min), .frame_done(frame_done),
    .frame_start(frame_start), .sync_lost(sync_lost)
  );

  task automatic check(input bit ok, input int req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL R%0d %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_obs();
    bit_no = 0; fs_cnt = 0; fs_pos = 0; sl_cnt = 0; sl_pos = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bit_valid = 1'b0; frame_done = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    clear_obs();
  endtask

  // Each call takes one cycle; outputs sampled at the next falling edge.
  task automatic send(input logic b);
    bit_valid = 1'b1; bit_in = b;
    @(posedge clk);
    @(negedge clk);
    bit_valid = 1'b0;
    bit_no++;
    if (frame_start) begin fs_cnt++; if (fs_pos == 0) fs_pos = bit_no; end
    if (sync_lost)   begin sl_cnt++; if (sl_pos == 0) sl_pos = bit_no; end
  endtask

  task automatic idle(input logic b);
    bit_valid = 1'b0; bit_in = b;
    @(posedge clk);
    @(negedge clk);
    if (frame_start) fs_cnt++;
    if (sync_lost)   sl_cnt++;
  endtask

  task automatic send_word(input logic [63:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) send(w[i]);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    check(frame_start == 1'b0, 1, "frame_start after reset", int'(frame_start), 0);
    check(sync_lost == 1'b0, 1, "sync_lost after reset", int'(sync_lost), 0);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      mod_fm = V_FM[v][0]; line_manch = V_MAN[v][0];
      sof_alt_sel = V_ALT[v][0]; pre_min = PRE_W'(V_PRE[v]);
      do_reset();
      send_word(V_BITS[v], V_N[v]);
      check(fs_pos == V_FS[v] && fs_cnt == (V_FS[v] != 0 ? 1 : 0), V_REQ[v],
            $sformatf("vector %0d frame_start bit", v), fs_pos, V_FS[v]);
      check(sl_pos == V_SL[v] && sl_cnt == (V_SL[v] != 0 ? 1 : 0), V_REQ[v],
            $sformatf("vector %0d sync_lost bit", v), sl_pos, V_SL[v]);
    end

    // R10 idle cycles carrying break values leave the run intact
    mod_fm = 1'b1; line_manch = 1'b0; sof_alt_sel = 1'b0; pre_min = 6'd8;
    do_reset();
    for (int i = 0; i < 8; i++) begin
      send(i % 2 == 0 ? 1'b1 : 1'b0);
      idle(i % 2 == 0 ? 1'b1 : 1'b0);
    end
    check(fs_cnt == 0, 10, "no pulse from idle cycles", fs_cnt, 0);
    send(1'b0);
    check(fs_pos == 9 && fs_cnt == 1, 10, "frame_start after gapped preamble", fs_pos, 9);

    // R9 pulse is one cycle wide
    idle(1'b0);
    check(fs_cnt == 1, 9, "frame_start width", fs_cnt, 1);

    // R8 hold until frame_done, then rearm
    line_manch = 1'b1;
    do_reset();
    send_word(64'hFF55, 16);
    check(fs_pos == 16, 8, "first frame start", fs_pos, 16);
    clear_obs();
    send_word(64'hFF55, 16);
    check(fs_cnt == 0, 8, "bits ignored while held", fs_cnt, 0);
    frame_done = 1'b1;
    idle(1'b0);
    frame_done = 1'b0;
    clear_obs();
    send_word(64'hFF55, 16);
    check(fs_pos == 16 && fs_cnt == 1, 8, "rearmed after frame_done", fs_pos, 16);

    // R9 sync_lost one cycle wide, and a fresh preamble is needed after it (R6)
    do_reset();
    send_word(64'hFF_0000_0000, 40);
    check(sl_pos == 40, 6, "sync_lost at window end", sl_pos, 40);
    idle(1'b0);
    check(sl_cnt == 1, 9, "sync_lost width", sl_cnt, 1);
    clear_obs();
    send_word(64'hFF55, 16);
    check(fs_pos == 16, 6, "frame after re-search", fs_pos, 16);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule